// File: doc/BRIEF.md
# Mean Shift Centroid Update Unit

This block performs one mean shift step over a rectangular candidate window of at most 64×64 pixels. After a start pulse it latches the window bounds and takes the colour-bin index of each window pixel as a stream. It uses each bin index as a histogram read address. From the target-model and candidate-model counts it reads back, it forms a per-pixel weight equal to the square root of the target-to-candidate ratio.

The ratio comes from a fully pipelined divider and the root from a fully pipelined square-root unit. Both accept one operand per clock. The pixel coordinates travel beside the data through tag registers, so that each coordinate meets its own weight at the accumulators. The accumulators hold the weighted x sum, the weighted y sum and the weight sum.

When every weight is summed, the controller issues the two centroid quotients to the same divider. It then presents the new window centre with a one-cycle done pulse. A surrounding tracking loop runs the unit repeatedly until the centre settles.

Top module: `msc_update`

## Requirements
- R1: After reset, done and err are 0 and new_x and new_y are 0.
- R2: Each pixel's weight is the integer square root of the ratio floor(t·65536/c), where t and c are the target and candidate counts at that pixel's bin. The weight is an unsigned value with 8 fraction bits. The new centre is floor(Σx·w / Σw) for x and floor(Σy·w / Σw) for y, taken over every window pixel, with x and y as absolute image coordinates.
- R3: A pixel whose candidate count is 0 gets weight 0, whatever its target count.
- R4: A ratio that does not fit in 32 bits is clamped to 2^32−1, which gives weight 65535.
- R5: If the weight sum is 0, new_x is floor((x_lo+x_hi)/2) and new_y is floor((y_lo+y_hi)/2), and err is 1 with done. A run with a nonzero weight sum returns err 0.
- R6: Pixels are taken in raster order from (x_lo, y_lo), with x advancing first. hist_addr equals the accepted bin one cycle after acceptance. Both histogram data inputs are sampled one cycle after that.
- R7: Idle cycles (pix_valid low) inside the stream do not change the result.
- R8: Pixels beyond the window count, and start pulses while a step is running, are ignored and leave the result unchanged.
- R9: done is high for exactly one cycle. new_x, new_y and err hold their values until the next done.
- R10: The new centre always lies inside the window bounds.
- R11: done rises exactly 2·DIV_LAT + SQRT_LAT + 4 clock edges after the edge that accepts the last window pixel (83 with defaults).
- R12: A full 64×64 window with every weight at 65535 yields the exact centroid, with no accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a step; bounds sampled in the same cycle |
| win_x_lo | input | COORD_W | Left column of the window |
| win_y_lo | input | COORD_W | Top row of the window |
| win_x_hi | input | COORD_W | Right column of the window (inclusive) |
| win_y_hi | input | COORD_W | Bottom row of the window (inclusive) |
| pix_valid | input | 1 | A pixel bin is offered this cycle |
| pix_bin | input | BIN_W | Colour-bin index of the offered pixel |
| hist_addr | output | BIN_W | Histogram read address (registered) |
| tgt_rdata | input | HIST_W | Target-model count read back for hist_addr |
| cand_rdata | input | HIST_W | Candidate-model count read back for hist_addr |
| new_x | output | COORD_W | New window centre, x |
| new_y | output | COORD_W | New window centre, y |
| done | output | 1 | One-cycle pulse when the new centre is valid |
| err | output | 1 | Weight sum was zero in the last step |

## Verification
On every cycle the assertions check four things: the done pulse is a single cycle, the result lies inside the latched window, a histogram address follows each accepted pixel, and weights reach the accumulators only during the scan. They also check that a rising err coincides with done. The numeric behaviour can only be shown by the bench's scenarios, which compare against an independent model of the weight and centroid arithmetic. That behaviour covers the weight formula, zero candidate bins, clamped ratios and the zero-sum fallback. The scenarios also cover stream gaps, surplus pixels, stray start pulses, the exact latency and the full-size window.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ISSUE_X,
    ST_ISSUE_Y,
    ST_WAIT
  } msc_state_e;
endpackage

// File: rtl/msc_delay_line.sv
module msc_delay_line #(
  parameter int W   = 8,
  parameter int LAT = 4
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [LAT-1:0] vld;
  logic [W-1:0]   dat [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld[0] <= in_valid;
      for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
    end
    dat[0] <= in_data;
    for (int i = 1; i < LAT; i++) dat[i] <= dat[i-1];
  end

  assign out_valid = vld[LAT-1];
  assign out_data  = dat[LAT-1];
endmodule

// File: rtl/msc_pipe_div.sv
module msc_pipe_div #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32,
  parameter int LAT   = 34,
  parameter int TAG_W = 4
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [NUM_W-1:0] quo,
  output logic [TAG_W-1:0] out_tag
);
  logic [NUM_W-1:0] q_raw;

  always_comb begin
    if (den == '0) q_raw = '0;
    else           q_raw = num / NUM_W'(den);
  end

  msc_delay_line #(.W(NUM_W + TAG_W), .LAT(LAT)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  ({q_raw, in_tag}),
    .out_valid(out_valid),
    .out_data ({quo, out_tag})
  );
endmodule

// File: rtl/msc_pipe_sqrt.sv
module msc_pipe_sqrt #(
  parameter int IN_W  = 32,
  parameter int LAT   = 11,
  parameter int TAG_W = 4,
  localparam int OUT_W = IN_W / 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  radicand,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [OUT_W-1:0] root,
  output logic [TAG_W-1:0] out_tag
);
  function automatic logic [OUT_W-1:0] isqrt(input logic [IN_W-1:0] v);
    logic [OUT_W-1:0] r;
    logic [IN_W-1:0]  t;
    r = '0;
    for (int i = OUT_W - 1; i >= 0; i--) begin
      t = {{(IN_W - OUT_W){1'b0}}, r | (OUT_W'(1) << i)};
      if (t * t <= v) r = r | (OUT_W'(1) << i);
    end
    return r;
  endfunction

  logic [OUT_W-1:0] r_raw;
  assign r_raw = isqrt(radicand);

  msc_delay_line #(.W(OUT_W + TAG_W), .LAT(LAT)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  ({r_raw, in_tag}),
    .out_valid(out_valid),
    .out_data ({root, out_tag})
  );
endmodule

// File: rtl/msc_update.sv
module msc_update
  import msc_pkg::*;
#(
  parameter int COORD_W  = 6,
  parameter int BIN_W    = 8,
  parameter int HIST_W   = 32,
  parameter int FRAC_W   = 16,
  parameter int DIV_LAT  = 34,
  parameter int SQRT_LAT = 11
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [COORD_W-1:0] win_x_lo,
  input  logic [COORD_W-1:0] win_y_lo,
  input  logic [COORD_W-1:0] win_x_hi,
  input  logic [COORD_W-1:0] win_y_hi,
  input  logic               pix_valid,
  input  logic [BIN_W-1:0]   pix_bin,
  output logic [BIN_W-1:0]   hist_addr,
  input  logic [HIST_W-1:0]  tgt_rdata,
  input  logic [HIST_W-1:0]  cand_rdata,
  output logic [COORD_W-1:0] new_x,
  output logic [COORD_W-1:0] new_y,
  output logic               done,
  output logic               err
);
  localparam int CNT_W = 2 * COORD_W + 1;
  localparam int W_W   = HIST_W / 2;
  localparam int WS_W  = W_W + 2 * COORD_W;
  localparam int ACC_W = COORD_W + WS_W;
  localparam int NUM_W = (HIST_W + FRAC_W > ACC_W) ? HIST_W + FRAC_W : ACC_W;
  localparam int DEN_W = (HIST_W > WS_W) ? HIST_W : WS_W;
  localparam int CT_W  = 2 * COORD_W;
  localparam int TAG_W = 2 + CT_W;

  msc_state_e st;
  logic [COORD_W-1:0] lx, ly, hx, hy, cx, cy;
  logic [CNT_W-1:0]   npix, in_cnt, acc_cnt;
  logic               a_vld, b_vld;
  logic [COORD_W-1:0] a_x, a_y, b_x, b_y, x_res;
  logic [ACC_W-1:0]   xsum, ysum;
  logic [WS_W-1:0]    wsum;
  logic               accept;

  logic             d_vld, q_vld, s_vld;
  logic [NUM_W-1:0] d_num, q_val;
  logic [DEN_W-1:0] d_den;
  logic [TAG_W-1:0] d_tag, q_tag;
  logic [HIST_W-1:0] ratio;
  logic [W_W-1:0]   w_out;
  logic [CT_W-1:0]  s_tag;
  logic [COORD_W-1:0] s_x, s_y;

  assign accept = (st == ST_SCAN) && pix_valid && (in_cnt != npix);

  // Shared divider input: per-pixel ratios during the scan, centroid quotients afterwards
  always_comb begin
    d_vld = 1'b0;
    d_num = '0;
    d_den = '0;
    d_tag = '0;
    if (st == ST_ISSUE_X || st == ST_ISSUE_Y) begin
      d_vld = (wsum != '0);
      d_num = NUM_W'((st == ST_ISSUE_Y) ? ysum : xsum);
      d_den = DEN_W'(wsum);
      d_tag = {1'b1, st == ST_ISSUE_Y, {CT_W{1'b0}}};
    end else if (b_vld) begin
      d_vld = 1'b1;
      d_num = NUM_W'({tgt_rdata, {FRAC_W{1'b0}}});
      d_den = DEN_W'(cand_rdata);
      d_tag = {2'b00, b_x, b_y};
    end
  end

  msc_pipe_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .LAT(DIV_LAT), .TAG_W(TAG_W)) u_div (
    .clk(clk), .rst(rst),
    .in_valid(d_vld), .num(d_num), .den(d_den), .in_tag(d_tag),
    .out_valid(q_vld), .quo(q_val), .out_tag(q_tag)
  );

  assign ratio = (|q_val[NUM_W-1:HIST_W]) ? {HIST_W{1'b1}} : q_val[HIST_W-1:0];

  msc_pipe_sqrt #(.IN_W(HIST_W), .LAT(SQRT_LAT), .TAG_W(CT_W)) u_sqrt (
    .clk(clk), .rst(rst),
    .in_valid(q_vld && !q_tag[TAG_W-1]), .radicand(ratio), .in_tag(q_tag[CT_W-1:0]),
    .out_valid(s_vld), .root(w_out), .out_tag(s_tag)
  );

  assign s_x = s_tag[CT_W-1:COORD_W];
  assign s_y = s_tag[COORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      lx <= '0; ly <= '0; hx <= '0; hy <= '0; cx <= '0; cy <= '0;
      npix <= '0; in_cnt <= '0; acc_cnt <= '0;
      a_vld <= 1'b0; b_vld <= 1'b0;
      xsum <= '0; ysum <= '0; wsum <= '0;
      hist_addr <= '0; x_res <= '0;
      new_x <= '0; new_y <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done  <= 1'b0;
      a_vld <= accept;
      b_vld <= a_vld;
      b_x   <= a_x;
      b_y   <= a_y;
      if (accept) begin
        a_x       <= cx;
        a_y       <= cy;
        hist_addr <= pix_bin;
        in_cnt    <= in_cnt + 1'b1;
        if (cx == hx) begin
          cx <= lx;
          cy <= cy + 1'b1;
        end else begin
          cx <= cx + 1'b1;
        end
      end
      case (st)
        ST_IDLE: if (start) begin
          lx <= win_x_lo; ly <= win_y_lo; hx <= win_x_hi; hy <= win_y_hi;
          cx <= win_x_lo; cy <= win_y_lo;
          npix <= CNT_W'((32'(win_x_hi) - 32'(win_x_lo) + 32'd1) *
                         (32'(win_y_hi) - 32'(win_y_lo) + 32'd1));
          in_cnt <= '0; acc_cnt <= '0;
          xsum <= '0; ysum <= '0; wsum <= '0;
          st <= ST_SCAN;
        end
        ST_SCAN: if (s_vld) begin
          xsum    <= xsum + ACC_W'(s_x) * ACC_W'(w_out);
          ysum    <= ysum + ACC_W'(s_y) * ACC_W'(w_out);
          wsum    <= wsum + WS_W'(w_out);
          acc_cnt <= acc_cnt + 1'b1;
          if (acc_cnt == npix - 1'b1) st <= ST_ISSUE_X;
        end
        ST_ISSUE_X: if (wsum == '0) begin
          new_x <= COORD_W'((32'(lx) + 32'(hx)) >> 1);
          new_y <= COORD_W'((32'(ly) + 32'(hy)) >> 1);
          err   <= 1'b1;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end else begin
          st <= ST_ISSUE_Y;
        end
        ST_ISSUE_Y: st <= ST_WAIT;
        ST_WAIT: if (q_vld && q_tag[TAG_W-1]) begin
          if (!q_tag[TAG_W-2]) begin
            x_res <= q_val[COORD_W-1:0];
          end else begin
            new_x <= x_res;
            new_y <= q_val[COORD_W-1:0];
            err   <= 1'b0;
            done  <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: completion strobe lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: result stays inside the latched window
  assert_centre_in_window_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_x >= lx && new_x <= hx && new_y >= ly && new_y <= hy));

  // R6: every accepted pixel issues its bin as the next read address
  assert_hist_addr_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (hist_addr == $past(pix_bin)));

  // R8: weights only reach the accumulators while scanning
  assert_weight_in_scan_R8: assert property (@(posedge clk) disable iff (rst)
    s_vld |-> (st == ST_SCAN));

  // R5: the error flag is raised only together with completion
  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

// File: tb/msc_update_tb_top.sv
module msc_update_tb_top;
  localparam int COORD_W = 6;
  localparam int BIN_W = 8;
  localparam int HIST_W = 32;
  localparam int DIV_LAT = 34;
  localparam int SQRT_LAT = 11;
  localparam int EXP_LAT = 2 * DIV_LAT + SQRT_LAT + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [COORD_W-1:0] win_x_lo = '0, win_y_lo = '0, win_x_hi = '0, win_y_hi = '0;
  logic pix_valid = 1'b0;
  logic [BIN_W-1:0] pix_bin = '0;
  logic [BIN_W-1:0] hist_addr;
  logic [HIST_W-1:0] tgt_rdata, cand_rdata;
  logic [COORD_W-1:0] new_x, new_y;
  logic done, err;

  logic [HIST_W-1:0] tgt_mem [256];
  logic [HIST_W-1:0] cand_mem [256];

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int got_x, got_y, got_err, got_lat, exp_x, exp_y, exp_err;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    tgt_rdata  <= tgt_mem[hist_addr];
    cand_rdata <= cand_mem[hist_addr];
  end

  msc_update dut_i (
    .clk(clk), .rst(rst), .start(start),
    .win_x_lo(win_x_lo), .win_y_lo(win_y_lo), .win_x_hi(win_x_hi), .win_y_hi(win_y_hi),
    .pix_valid(pix_valid), .pix_bin(pix_bin), .hist_addr(hist_addr),
    .tgt_rdata(tgt_rdata), .cand_rdata(cand_rdata),
    .new_x(new_x), .new_y(new_y), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned ref_w(input longint unsigned t, input longint unsigned c);
    longint unsigned r, root, cand;
    if (c == 0) return 0;
    r = (t << 16) / c;
    if (r > 64'hFFFF_FFFF) r = 64'hFFFF_FFFF;
    root = 0;
    for (int b = 15; b >= 0; b--) begin
      cand = root + (64'd1 << b);
      if (cand * cand <= r) root = cand;
    end
    return root;
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < 256; i++) begin
      case (mode)
        0: begin tgt_mem[i] = 1000; cand_mem[i] = 1000; end
        1: begin
          tgt_mem[i]  = 32'((i * 37) % 1000 + 1);
          cand_mem[i] = (i % 5 == 0) ? 32'd0 : 32'((i * 53) % 997 + 1);
          if (i % 17 == 0) begin tgt_mem[i] = 32'h0010_0000; cand_mem[i] = 3; end
        end
        2: begin
          if (i % 2 == 0) begin tgt_mem[i] = 32'h00FF_FFFF; cand_mem[i] = 0; end
          else begin tgt_mem[i] = 32'((i * 29) % 500 + 10); cand_mem[i] = 32'((i * 11) % 300 + 5); end
        end
        3: begin
          if (i % 2 == 1) begin tgt_mem[i] = 32'h0010_0000; cand_mem[i] = 1; end
          else begin tgt_mem[i] = 1000; cand_mem[i] = 1000; end
        end
        4: begin tgt_mem[i] = 0; cand_mem[i] = 1000; end
        default: begin tgt_mem[i] = 32'h0100_0000; cand_mem[i] = 1; end
      endcase
    end
  endtask

  task automatic run_win(input int lx, input int ly, input int hx, input int hy, input int seed,
                         input bit gaps, input int extra, input bit poke);
    longint unsigned xs, ys, ws, w;
    int k, last, wd;
    int b;
    xs = 0; ys = 0; ws = 0; k = 0; last = 0;
    @(negedge clk);
    start = 1'b1;
    win_x_lo = COORD_W'(lx); win_y_lo = COORD_W'(ly);
    win_x_hi = COORD_W'(hx); win_y_hi = COORD_W'(hy);
    @(negedge clk);
    start = 1'b0;
    for (int y = ly; y <= hy; y++) begin
      for (int x = lx; x <= hx; x++) begin
        b = (x * 7 + y * 13 + seed) & 255;
        w = ref_w(longint'(tgt_mem[b]), longint'(cand_mem[b]));
        xs += longint'(x) * w; ys += longint'(y) * w; ws += w;
        if (gaps && ((x + y) % 3 == 0)) begin
          pix_valid = 1'b0;
          @(negedge clk);
        end
        pix_valid = 1'b1;
        pix_bin = BIN_W'(b);
        if (poke && k == 2) begin
          start = 1'b1; win_x_lo = '0; win_y_lo = '0; win_x_hi = '1; win_y_hi = '1;
        end
        @(negedge clk);
        start = 1'b0;
        chk(hist_addr == BIN_W'(b), "R6 hist_addr", hist_addr, b);
        last = int'(cyc);
        k++;
      end
    end
    for (int e = 0; e < extra; e++) begin
      pix_valid = 1'b1;
      pix_bin = BIN_W'(e * 3);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      chk(1'b0, "watchdog", wd, 0);
      return;
    end
    got_x = int'(new_x); got_y = int'(new_y); got_err = int'(err);
    got_lat = int'(cyc) - last;
    if (ws == 0) begin
      exp_x = (lx + hx) / 2; exp_y = (ly + hy) / 2; exp_err = 1;
    end else begin
      exp_x = int'(xs / ws); exp_y = int'(ys / ws); exp_err = 0;
    end
    @(negedge clk);
    chk(!done, "R9 done pulse width", done, 0);
    chk(int'(new_x) == got_x && int'(new_y) == got_y, "R9 result hold", new_x, got_x);
  endtask

  task automatic t_reset;
    chk(!done, "R1 done", done, 0);
    chk(!err, "R1 err", err, 0);
    chk(new_x == 0 && new_y == 0, "R1 centre", new_x, 0);
  endtask

  task automatic t_uniform;
    fill(0);
    run_win(10, 20, 13, 22, 0, 1'b0, 0, 1'b0);
    chk(got_x == 11, "R2 uniform x", got_x, 11);
    chk(got_y == 21, "R2 uniform y", got_y, 21);
    chk(got_err == 0, "R5 err clear", got_err, 0);
    chk(got_lat == EXP_LAT, "R11 latency", got_lat, EXP_LAT);
  endtask

  task automatic t_mixed;
    fill(1);
    run_win(5, 30, 17, 38, 3, 1'b1, 5, 1'b1);
    chk(got_x == exp_x, "R2 R7 R8 mixed x", got_x, exp_x);
    chk(got_y == exp_y, "R2 R7 R8 mixed y", got_y, exp_y);
    chk(got_err == exp_err, "R2 mixed err", got_err, exp_err);
    chk(got_lat == EXP_LAT, "R11 latency with gaps", got_lat, EXP_LAT);
  endtask

  task automatic t_zero_cand;
    fill(2);
    run_win(0, 0, 9, 6, 1, 1'b0, 0, 1'b0);
    chk(got_x == exp_x, "R3 zero candidate x", got_x, exp_x);
    chk(got_y == exp_y, "R3 zero candidate y", got_y, exp_y);
  endtask

  task automatic t_sat;
    fill(3);
    run_win(20, 2, 31, 9, 0, 1'b0, 0, 1'b0);
    chk(got_x == exp_x, "R4 clamp x", got_x, exp_x);
    chk(got_y == exp_y, "R4 clamp y", got_y, exp_y);
  endtask

  task automatic t_all_zero;
    fill(4);
    run_win(3, 40, 8, 45, 0, 1'b0, 0, 1'b0);
    chk(got_err == 1, "R5 err set", got_err, 1);
    chk(got_x == 5, "R5 midpoint x", got_x, 5);
    chk(got_y == 42, "R5 midpoint y", got_y, 42);
    chk(err == 1'b1, "R9 err held", err, 1);
  endtask

  task automatic t_single;
    fill(0);
    run_win(63, 0, 63, 0, 0, 1'b0, 0, 1'b0);
    chk(got_x == 63 && got_y == 0, "R10 single pixel", got_x, 63);
    chk(got_err == 0, "R5 err cleared", got_err, 0);
  endtask

  task automatic t_full;
    fill(5);
    run_win(0, 0, 63, 63, 0, 1'b0, 0, 1'b0);
    chk(got_x == 31, "R12 full window x", got_x, 31);
    chk(got_y == 31, "R12 full window y", got_y, 31);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_uniform();
    t_mixed();
    t_zero_cand();
    t_sat();
    t_all_zero();
    t_single();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule